// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block decides which of two reference clocks feeds a frequency-synthesis loop. It watches a validity flag for each reference, provided by a separate qualification monitor, and a user select request. In automatic operation it begins on the requested reference. If the reference in use is lost, it moves to the other reference. If both are lost, it enters holdover. A user can also request a switch by changing the select input. In manual operation the choice follows the select input directly.

Every change of reference raises an active-low busy indication. Busy stays low until the loop reports that the phase has been realigned, or until a timeout measured in compare ticks runs out. While reset is held, the status outputs are forced to a defined idle pattern. The select input is synchronised to the clock and must be held for a minimum number of compare ticks before it counts.

Top module: `ref_failover_ctrl`

## Requirements
- R1: While reset is asserted, activeRef is 0, failN is 2'b11, lockN is 1, busyN is 1 and holdover is 0.
- R2: After reset is released in automatic mode, the controller settles on the reference named by the qualified select level without a busy phase.
- R3: In automatic mode, when the reference in use loses its valid flag and the other reference is valid, the controller switches to the other reference.
- R4: After an automatic failover, the controller stays on the backup while the backup remains valid, even when the original reference becomes valid again.
- R5: In automatic mode, a qualified change of the select level starts a switch only if the requested reference differs from the active one and its valid flag is 1.
- R6: A select level held for fewer than MIN_TICKS (default 2) compare ticks is ignored.
- R7: In automatic mode, when neither reference is valid, holdover is 1, activeRef is 0, busyN is 1 and lockN is 1.
- R8: On leaving holdover, if both references are valid together, the one named by the select level is used. If only one is valid, that one is used.
- R9: If the target reference loses its valid flag during a switch, the controller enters holdover and switches back to that reference once it is valid again.
- R10: busyN is 0 from the start of a switch until alignDone is pulsed, or until ALIGN_TIMEOUT compare ticks have elapsed.
- R11: In manual mode (manualMode=1), activeRef follows the qualified select level whether or not that reference is valid, and holdover is never entered.
- R12: bypass=1 forces manual-mode behaviour.
- R13: Outside reset, failN bit n equals refValid bit n (bit 0 is reference 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| tick | input | 1 | One-cycle strobe per compare cycle of the loop |
| selReq | input | 1 | Requested reference (0 or 1), asynchronous |
| manualMode | input | 1 | 1 selects manual switching, 0 selects automatic switching |
| bypass | input | 1 | 1 forces manual-mode behaviour |
| refValid | input | 2 | Per-reference valid flag from the qualification monitor, bit n for reference n |
| alignDone | input | 1 | Pulse from the loop when phase realignment is complete |
| activeRef | output | 1 | Index of the reference driving the loop |
| busyN | output | 1 | Low while a switch is in progress |
| holdover | output | 1 | High while no reference drives the loop |
| lockN | output | 1 | High during reset and in holdover |
| failN | output | 2 | Per-reference status, high meaning good, forced high in reset |

## Verification
The bound checker enforces four properties on every cycle: the forced reset pattern, the holdover output pattern, the absence of holdover under a held manual or bypass request, and a valid target for every automatic switch. It also checks that a change of the active reference while locked always comes with busy low. Other behaviours depend on history and can only be shown by the bench's scenarios. These are the stickiness after a failover, the choice of reference on leaving holdover, the fall into holdover during a switch, the rejection of short select pulses, and the release of busy by timeout.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_LOCK_PRIMARY,
    ST_SWITCHING,
    ST_LOCKED,
    ST_HOLDOVER
  } swState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrRun;
  } ctrlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic selLvl;
    logic selChg;
    logic selReady;
    logic alignTimeout;
  } dpStatus_t;

endpackage

// File: rtl/refsw_datapath.sv
module refsw_datapath
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_TICKS     = 2,
  parameter int ALIGN_TIMEOUT = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         selReq,
  input  ctrlStrobes_t strb,
  output dpStatus_t    stat
);

  localparam int QW = $clog2(MIN_TICKS + 1);
  localparam int TW = $clog2(ALIGN_TIMEOUT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   selSynced;
  logic                   cand;
  logic [QW-1:0]          qCnt;
  logic                   selLvl;
  logic                   selReady;
  logic                   selChg;
  logic [TW-1:0]          tmr;

  // metastability chain for the asynchronous select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], selReq};
  end
  assign selSynced = syncQ[SYNC_STAGES-1];

  // level qualification in compare ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cand     <= 1'b0;
      qCnt     <= '0;
      selLvl   <= 1'b0;
      selReady <= 1'b0;
      selChg   <= 1'b0;
    end else begin
      selChg <= 1'b0;
      if (selSynced != cand) begin
        cand <= selSynced;
        qCnt <= '0;
      end else if (tick && (qCnt < QW'(MIN_TICKS))) begin
        qCnt <= qCnt + 1'b1;
      end
      if ((qCnt == QW'(MIN_TICKS)) && (selSynced == cand) &&
          (!selReady || (selLvl != cand))) begin
        selLvl   <= cand;
        selReady <= 1'b1;
        selChg   <= selReady;
      end
    end
  end

  // realignment timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                              tmr <= '0;
    else if (strb.tmrClr)                                   tmr <= '0;
    else if (strb.tmrRun && tick && (tmr < TW'(ALIGN_TIMEOUT))) tmr <= tmr + 1'b1;
  end

  assign stat.selLvl       = selLvl;
  assign stat.selChg       = selChg;
  assign stat.selReady     = selReady;
  assign stat.alignTimeout = (tmr == TW'(ALIGN_TIMEOUT));

endmodule

// File: rtl/refsw_control.sv
module refsw_control
  import refsw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         manualEff,
  input  logic [1:0]   refValid,
  input  logic         alignDone,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output logic         activeRef,
  output logic         busyN,
  output logic         holdover,
  output logic         lockN,
  output logic         inReset
);

  swState_e state, nextState;
  logic     nextRef;
  logic     startSw;
  logic     otherRef;

  assign otherRef = ~activeRef;

  always_comb begin
    nextState = state;
    nextRef   = activeRef;
    startSw   = 1'b0;
    unique case (state)
      ST_RESET: begin
        if (stat.selReady) begin
          nextRef   = stat.selLvl;
          nextState = manualEff ? ST_LOCKED : ST_LOCK_PRIMARY;
        end
      end
      ST_LOCK_PRIMARY, ST_LOCKED: begin
        if (manualEff) begin
          if (stat.selLvl != activeRef) begin
            startSw = 1'b1;
            nextRef = stat.selLvl;
          end
        end else if (!refValid[activeRef]) begin
          if (refValid[otherRef]) begin
            startSw = 1'b1;
            nextRef = otherRef;
          end else begin
            nextState = ST_HOLDOVER;
            nextRef   = 1'b0;
          end
        end else if (stat.selChg && (stat.selLvl != activeRef) &&
                     refValid[stat.selLvl]) begin
          startSw = 1'b1;
          nextRef = stat.selLvl;
        end
      end
      ST_SWITCHING: begin
        if (manualEff) begin
          if (stat.selLvl != activeRef) begin
            startSw = 1'b1;
            nextRef = stat.selLvl;
          end else if (alignDone || stat.alignTimeout) begin
            nextState = ST_LOCKED;
          end
        end else if (!refValid[activeRef]) begin
          nextState = ST_HOLDOVER;
          nextRef   = 1'b0;
        end else if (alignDone || stat.alignTimeout) begin
          nextState = ST_LOCKED;
        end
      end
      ST_HOLDOVER: begin
        if (manualEff || (&refValid)) begin
          startSw = 1'b1;
          nextRef = stat.selLvl;
        end else if (refValid[0]) begin
          startSw = 1'b1;
          nextRef = 1'b0;
        end else if (refValid[1]) begin
          startSw = 1'b1;
          nextRef = 1'b1;
        end
      end
      default: nextState = ST_RESET;
    endcase
    if (startSw) nextState = ST_SWITCHING;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RESET;
      activeRef <= 1'b0;
    end else begin
      state     <= nextState;
      activeRef <= nextRef;
    end
  end

  assign strb.tmrClr = startSw;
  assign strb.tmrRun = (state == ST_SWITCHING);
  assign busyN       = (state != ST_SWITCHING);
  assign holdover    = (state == ST_HOLDOVER);
  assign lockN       = (state == ST_RESET) || (state == ST_HOLDOVER);
  assign inReset     = (state == ST_RESET);

endmodule

// File: rtl/ref_failover_ctrl.sv
module ref_failover_ctrl
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_TICKS     = 2,
  parameter int ALIGN_TIMEOUT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       selReq,
  input  logic       manualMode,
  input  logic       bypass,
  input  logic [1:0] refValid,
  input  logic       alignDone,
  output logic       activeRef,
  output logic       busyN,
  output logic       holdover,
  output logic       lockN,
  output logic [1:0] failN
);

  logic [1:0]   rstSync;
  logic         rstInt;
  logic         inReset;
  ctrlStrobes_t strb;
  dpStatus_t    stat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstSync <= 2'b00;
    else       rstSync <= {rstSync[0], 1'b1};
  end
  assign rstInt = rstSync[1];

  refsw_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .MIN_TICKS    (MIN_TICKS),
    .ALIGN_TIMEOUT(ALIGN_TIMEOUT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstInt),
    .tick  (tick),
    .selReq(selReq),
    .strb  (strb),
    .stat  (stat)
  );

  refsw_control u_ctrl (
    .clk      (clk),
    .rstN     (rstInt),
    .manualEff(manualMode | bypass),
    .refValid (refValid),
    .alignDone(alignDone),
    .stat     (stat),
    .strb     (strb),
    .activeRef(activeRef),
    .busyN    (busyN),
    .holdover (holdover),
    .lockN    (lockN),
    .inReset  (inReset)
  );

  assign failN = inReset ? 2'b11 : refValid;

endmodule

// File: rtl/refsw_checker.sv
module refsw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       manualMode,
  input logic       bypass,
  input logic [1:0] refValid,
  input logic       activeRef,
  input logic       busyN,
  input logic       holdover,
  input logic       lockN,
  input logic [1:0] failN
);

  logic       manEff;
  logic [1:0] validQ;

  assign manEff = manualMode | bypass;

  always_ff @(posedge clk) validQ <= refValid;

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_status_r1: assert (activeRef == 1'b0 && busyN && lockN &&
                                 failN == 2'b11 && !holdover)
        else $error("reset status pattern violated");
    end
  end

  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdover |-> (activeRef == 1'b0 && busyN && lockN));

  p_manual_no_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (manEff && $past(manEff)) |-> !holdover);

  p_switch_target_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!manEff && !$past(manEff) && $fell(busyN)) |-> validQ[activeRef]);

  p_change_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!lockN && !$past(lockN) && (activeRef != $past(activeRef))) |-> !busyN);

endmodule

bind ref_failover_ctrl refsw_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .manualMode(manualMode),
  .bypass    (bypass),
  .refValid  (refValid),
  .activeRef (activeRef),
  .busyN     (busyN),
  .holdover  (holdover),
  .lockN     (lockN),
  .failN     (failN)
);

// File: tb/sim_ref_failover_ctrl.sv
module sim_ref_failover_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 26;

  // {req[3:0], sel, man, byp, valid[1:0], align, expAct, expBusyN, expHold}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0010_0_0_0_11_0_0_1_0,  // R2 starts on select 0
    13'b0011_0_0_0_10_0_1_0_0,  // R3 failover to ref 1, busy low
    13'b1010_0_0_0_10_1_1_1_0,  // R10 align releases busy
    13'b0100_0_0_0_11_0_1_1_0,  // R4 ref 0 back, stays on 1
    13'b0101_1_0_0_11_0_1_1_0,  // R5 select equals active, no switch
    13'b0101_0_0_0_10_0_1_1_0,  // R5 target invalid, no switch
    13'b0101_1_0_0_11_0_1_1_0,  // R5 back to 1, no switch
    13'b0101_0_0_0_11_0_0_0_0,  // R5 user switch to 0
    13'b1010_0_0_0_11_1_0_1_0,  // R10 align
    13'b0111_0_0_0_00_0_0_1_1,  // R7 both lost
    13'b0111_1_0_0_00_0_0_1_1,  // R7 select change in holdover
    13'b1000_1_0_0_11_0_1_0_0,  // R8 both back, select wins
    13'b1010_1_0_0_11_1_1_1_0,  // R10 align
    13'b0111_1_0_0_00_0_0_1_1,  // R7 holdover again
    13'b1000_1_0_0_01_0_0_0_0,  // R8 only ref 0 back
    13'b1010_1_0_0_01_1_0_1_0,  // R10 align
    13'b0011_1_0_0_10_0_1_0_0,  // R3 failover to 1
    13'b1001_1_0_0_00_0_0_1_1,  // R9 target lost mid switch
    13'b1001_1_0_0_10_0_1_0_0,  // R9 target requalified
    13'b1010_1_0_0_10_1_1_1_0,  // R10 align
    13'b1011_0_1_0_10_0_0_0_0,  // R11 manual to invalid ref 0
    13'b1011_0_1_0_10_1_0_1_0,  // R11 align
    13'b1011_0_1_0_00_0_0_1_0,  // R11 no holdover in manual
    13'b1011_1_1_0_00_1_1_1_0,  // R11 manual follows select
    13'b1100_0_0_1_00_1_0_1_0,  // R12 bypass acts as manual
    13'b1100_0_0_0_11_1_0_1_0   // R12 back to automatic
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic       selReq;
  logic       manualMode;
  logic       bypass;
  logic [1:0] refValid;
  logic       alignDone;
  logic       activeRef;
  logic       busyN;
  logic       holdover;
  logic       lockN;
  logic [1:0] failN;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_failover_ctrl u0 (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .selReq    (selReq),
    .manualMode(manualMode),
    .bypass    (bypass),
    .refValid  (refValid),
    .alignDone (alignDone),
    .activeRef (activeRef),
    .busyN     (busyN),
    .holdover  (holdover),
    .lockN     (lockN),
    .failN     (failN)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; tick = 1'b1; selReq = 1'b0; manualMode = 1'b0;
    bypass = 1'b0; refValid = 2'b00; alignDone = 1'b0;
    waitN(5);
    // R1: forced status in reset, fail flags high even with both invalid
    check("R1 reset pattern", {2'b0, activeRef, busyN, holdover, lockN, failN},
          {2'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11});
    refValid = 2'b11;
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [12:0] v = VEC[i];
      selReq = v[8]; manualMode = v[7]; bypass = v[6]; refValid = v[5:4];
      waitN(10);
      if (v[3]) begin
        alignDone = 1'b1;
        waitN(1);
        alignDone = 1'b0;
      end
      waitN(3);
      check($sformatf("R%0d step %0d", v[12:9], i),
            {4'b0, activeRef, busyN, holdover, lockN},
            {4'b0, v[2], v[1], v[0], v[0]});
    end

    // R13: fail flags mirror valid outside reset (ref 1 lost, active is 0)
    refValid = 2'b01;
    waitN(3);
    check("R13 fail flags", {6'b0, failN}, {6'b0, 2'b01});
    check("R13 no switch", {7'b0, activeRef}, 8'h00);
    refValid = 2'b11;
    waitN(3);

    // R6: select pulse of two cycles is too short to qualify
    selReq = 1'b1;
    waitN(2);
    selReq = 1'b0;
    waitN(15);
    check("R6 short select ignored", {6'b0, activeRef, busyN}, {6'b0, 1'b0, 1'b1});

    // R10: busy released by timeout without alignDone
    selReq = 1'b1;
    waitN(12);
    check("R10 switch busy", {6'b0, activeRef, busyN}, {6'b0, 1'b1, 1'b0});
    waitN(40);
    check("R10 timeout release", {6'b0, activeRef, busyN}, {6'b0, 1'b1, 1'b1});

    // R1: reset applied during operation
    rstN = 1'b0;
    refValid = 2'b00;
    waitN(2);
    check("R1 mid-run reset", {2'b0, activeRef, busyN, holdover, lockN, failN},
          {2'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11});

    // R2: start on reference 1 when select names it
    refValid = 2'b11;
    rstN = 1'b1;
    waitN(15);
    check("R2 start on select 1", {4'b0, activeRef, busyN, holdover, lockN},
          {4'b0, 1'b1, 1'b1, 1'b0, 1'b0});

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule